// File: doc/BRIEF.md
# Eight-Source Prioritised Interrupt Controller

This block sits between eight interrupt sources of a small 8-bit microcontroller and its CPU core. The sources are a USB bus reset, a fast 128 µs timer tick, a slower millisecond timer tick, three USB endpoints (each signals after a packet is sent or received on it), one shared line for the whole programmable-sink I/O port, and one shared line for all general-purpose I/O pins. The sink port and the general-purpose pins each get their own vector. Each incoming request sets a sticky pending flag. The two timer ticks are edge sources: a flag is set only when the timer bit goes from 0 to 1. The other six sources set their flag in every cycle where their request input is high.

Two software-visible enable registers mask the pending flags. The global register covers the five sources that are not endpoints, and the endpoint register covers the three endpoints. A master enable is set and cleared by the CPU and is dropped by hardware on acknowledge. A state machine with three states (`ST_OFF`, `ST_ARMED`, `ST_REQ`) picks the highest-priority enabled pending source, raises a request and presents its vector. Both stay frozen until the CPU acknowledges. The acknowledge clears the granted flag and disarms the master enable.

Transitions: `ST_OFF`→`ST_ARMED` on `ien_set` without `ien_clr`. `ST_ARMED`→`ST_OFF` on `ien_clr`. `ST_ARMED`→`ST_REQ` when any enabled flag is pending. `ST_REQ`→`ST_OFF` on `irq_ack`. Every other combination holds the state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, no flag is pending, both enable registers read 0, the master enable is off, `irq_req` is 0 and `irq_vec` is 0.
- R2: Request index 0 (bus reset), 3..5 (endpoints 0..2), 6 (sink port) and 7 (general-purpose I/O) set their pending flag when high at a clock edge. The flag is held, even while masked, until its own acknowledge.
- R3: Request index 1 (128 µs tick) and 2 (millisecond tick) set their flag only on a 0-to-1 change. A level held high sets the flag once.
- R4: Register address 0x20 holds the global enables: bit0 bus reset, bit1 128 µs tick, bit2 millisecond tick, bit3 sink port, bit4 general-purpose I/O; bits 7:5 read 0. Address 0x21 holds endpoint enables in bits 2:0 for endpoints 0..2; bits 7:3 read 0. Other addresses read 0 and ignore writes.
- R5: A pending flag whose enable bit is 0 never causes a request.
- R6: Priority is fixed by index: 0 highest, 7 lowest.
- R7: The vector of source index i is 2×(i+1). While no request is raised, `irq_vec` is 0.
- R8: `ien_set` arms the master enable and `ien_clr` disarms it (clear wins). A request is raised one cycle after an enabled flag is seen while armed. Acknowledge drops the request and disarms the master enable in the next cycle.
- R9: An acknowledge clears only the flag of the granted source.
- R10: A level request for the granted source in the same cycle as its acknowledge leaves that flag pending.
- R11: Once raised, `irq_req` and `irq_vec` stay unchanged until acknowledged, even if a higher-priority flag arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| src_req | input | 8 | Request lines, index = priority |
| ien_set | input | 1 | Arm master enable |
| ien_clr | input | 1 | Disarm master enable |
| ien_o | output | 1 | Master enable state |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the granted source |
| irq_ack | input | 1 | Acknowledge from the CPU |

## Verification
The assertions take for granted that the CPU pulses `irq_ack` only while `irq_req` is high. They also assume `ien_set` and `ien_clr` are never high together during a request. The checker recovers the granted index from `irq_vec` on that basis. The bench keeps to these rules: it acknowledges only after it has observed a raised request, and it drives each master-enable strobe alone for one cycle. Request pulses go low again before each drain, so the edge-detected ticks see a clean rising edge on every injection.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC  = 8;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 8;

    // Source indices, lowest index wins
    localparam int SRC_BUSRST = 0;
    localparam int SRC_T128   = 1;
    localparam int SRC_TMS    = 2;
    localparam int SRC_EP0    = 3;
    localparam int SRC_EP1    = 4;
    localparam int SRC_EP2    = 5;
    localparam int SRC_SINK   = 6;
    localparam int SRC_GPIO   = 7;

    // Timer ticks are rising-edge detected
    localparam logic [NSRC-1:0] EDGE_SRC_DEFAULT = 8'b0000_0110;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_REQ   = 2'd2
    } irq_state_e;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'((int'(idx) + 1) * 2);
    endfunction

endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] GLB_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] EPT_ADDR = 8'h21
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [irq_ctl_pkg::NSRC-1:0] en_mask
);
    localparam int GLB_BITS = 5;
    localparam int EPT_BITS = 3;

    logic [GLB_BITS-1:0] glb_q;
    logic [EPT_BITS-1:0] ept_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= '0;
            ept_q <= '0;
        end else if (wr) begin
            if (addr == GLB_ADDR) glb_q <= wdata[GLB_BITS-1:0];
            if (addr == EPT_ADDR) ept_q <= wdata[EPT_BITS-1:0];
        end
    end

    // gpio, sink, ep2..ep0, ms tick, 128us tick, bus reset
    assign en_mask = {glb_q[4], glb_q[3], ept_q, glb_q[2:0]};

    always_comb begin
        rdata = '0;
        if (addr == GLB_ADDR) rdata = DATA_W'(glb_q);
        else if (addr == EPT_ADDR) rdata = DATA_W'(ept_q);
    end

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int           N        = 8,
    parameter logic [N-1:0] EDGE_SEL = 8'b0000_0110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] set_w;

    for (genvar g = 0; g < N; g++) begin : g_src
        if (EDGE_SEL[g]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src_req[g];
            end
            assign set_w[g] = src_req[g] & ~prev_q;
        end else begin : g_level
            assign set_w[g] = src_req[g];
        end

        // a new request beats a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= (pend[g] & ~clr[g]) | set_w[g];
        end
    end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_ctl_pkg::*;
#(
    parameter logic [7:0]      GLB_ADDR = 8'h20,
    parameter logic [7:0]      EPT_ADDR = 8'h21,
    parameter logic [NSRC-1:0] EDGE_SEL = EDGE_SRC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [NSRC-1:0]  src_req,
    input  logic             ien_set,
    input  logic             ien_clr,
    output logic             ien_o,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack
);
    irq_state_e         state_q, state_d;
    logic [IDX_W-1:0]   grant_q;
    logic [NSRC-1:0]    en_mask;
    logic [NSRC-1:0]    pend_w;
    logic [NSRC-1:0]    clr_w;
    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;
    logic               take_grant;

    irq_enable_regs #(
        .ADDR_W  (8),
        .DATA_W  (8),
        .GLB_ADDR(GLB_ADDR),
        .EPT_ADDR(EPT_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en_mask(en_mask)
    );

    irq_pending #(
        .N       (NSRC),
        .EDGE_SEL(EDGE_SEL)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_req(src_req),
        .clr    (clr_w),
        .pend   (pend_w)
    );

    irq_prio #(
        .N    (NSRC),
        .IDX_W(IDX_W)
    ) u_prio (
        .req  (pend_w & en_mask),
        .found(cand_found),
        .idx  (cand_idx)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (ien_set && !ien_clr) state_d = ST_ARMED;
            ST_ARMED: if (ien_clr)             state_d = ST_OFF;
                      else if (cand_found)     state_d = ST_REQ;
            ST_REQ:   if (irq_ack)             state_d = ST_OFF;
            default:                           state_d = ST_OFF;
        endcase
    end

    assign take_grant = (state_q == ST_ARMED) && !ien_clr && cand_found;

    // state register and grant latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_grant) grant_q <= cand_idx;
        end
    end

    // outputs
    always_comb begin
        ien_o   = 1'b0;
        irq_req = 1'b0;
        irq_vec = '0;
        clr_w   = '0;
        unique case (state_q)
            ST_OFF: ;
            ST_ARMED: ien_o = 1'b1;
            ST_REQ: begin
                ien_o          = 1'b1;
                irq_req        = 1'b1;
                irq_vec        = vec_of(grant_q);
                clr_w[grant_q] = irq_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
    parameter int           N        = 8,
    parameter int           IDX_W    = 3,
    parameter int           VEC_W    = 8,
    parameter logic [N-1:0] EDGE_SEL = 8'b0000_0110
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     src_req,
    input logic             irq_ack,
    input logic             irq_req,
    input logic             ien_o,
    input logic [VEC_W-1:0] irq_vec,
    input logic [N-1:0]     pend
);
    logic [VEC_W-1:0] half_w;
    logic [IDX_W-1:0] gidx_w, gidx_q;
    logic             lvl_hit_w;

    assign half_w    = irq_vec >> 1;
    assign gidx_w    = IDX_W'(half_w - VEC_W'(1));
    assign lvl_hit_w = src_req[gidx_w] & ~EDGE_SEL[gidx_w];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gidx_q <= '0;
        else        gidx_q <= gidx_w;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (!irq_req && !ien_o));

    // R8
    off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_o |=> !irq_req);

    // R7
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[0] == 1'b0 && irq_vec != '0 && irq_vec <= VEC_W'(2 * N)));

    // R10
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && lvl_hit_w) |=> pend[gidx_q]);

endmodule

bind irq_vector_ctrl irq_ctl_checker #(
    .N       (irq_ctl_pkg::NSRC),
    .IDX_W   (irq_ctl_pkg::IDX_W),
    .VEC_W   (irq_ctl_pkg::VEC_W),
    .EDGE_SEL(EDGE_SEL)
) u_irq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_req(src_req),
    .irq_ack(irq_ack),
    .irq_req(irq_req),
    .ien_o  (ien_o),
    .irq_vec(irq_vec),
    .pend   (pend_w)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] src_req = '0;
    logic       ien_set = 1'b0;
    logic       ien_clr = 1'b0;
    logic       ien_o;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .ien_set(ien_set), .ien_clr(ien_clr), .ien_o(ien_o),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_mask(input logic [7:0] m);
        wr_reg(8'h20, {3'b000, m[7], m[6], m[2:0]});
        wr_reg(8'h21, {5'b00000, m[5:3]});
    endtask

    task automatic inject(input logic [7:0] p);
        src_req = p; step();
        src_req = '0; step();
    endtask

    task automatic arm_wait();
        ien_set = 1'b1; step();
        ien_set = 1'b0; step();
    endtask

    task automatic ack();
        irq_ack = 1'b1; step();
        irq_ack = 1'b0;
    endtask

    task automatic disarm();
        ien_clr = 1'b1; step();
        ien_clr = 1'b0;
    endtask

    // serve every enabled pending flag in expected priority order
    task automatic drain(input string tag, input logic [7:0] p, input logic [7:0] m);
        logic [7:0] rem;
        int lo;
        rem = p & m;
        while (rem != 0) begin
            lo = 0;
            for (int i = 7; i >= 0; i--) if (rem[i]) lo = i;
            arm_wait();
            chk({tag, " R6 req"}, irq_req, 1);
            chk({tag, " R6/R7 vec"}, irq_vec, 2 * (lo + 1));
            ack();
            chk({tag, " R8 disarm"}, ien_o, 0);
            rem[lo] = 1'b0;
        end
        arm_wait();
        chk({tag, " R9/R5 idle"}, irq_req, 0);
        disarm();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_vec", irq_vec, 0);
        chk("R1 ien_o", ien_o, 0);
        rd_chk("R1 glb", 8'h20, 8'h00);
        rd_chk("R1 ept", 8'h21, 8'h00);
        arm_wait();
        chk("R1 nothing pending", irq_req, 0);
        chk("R8 armed", ien_o, 1);
        disarm();
        chk("R8 ien_clr", ien_o, 0);

        // R4 register map
        wr_reg(8'h20, 8'hFF);
        wr_reg(8'h21, 8'hFF);
        wr_reg(8'h22, 8'hFF);
        rd_chk("R4 glb bits", 8'h20, 8'h1F);
        rd_chk("R4 ept bits", 8'h21, 8'h07);
        rd_chk("R4 other addr", 8'h22, 8'h00);
        wr_reg(8'h20, 8'h0A);
        rd_chk("R4 glb write", 8'h20, 8'h0A);
        rd_chk("R4 ept untouched", 8'h21, 8'h07);

        // R8 clear while armed blocks a request
        set_mask(8'h00);
        inject(8'h01);
        arm_wait();
        disarm();
        set_mask(8'hFF);
        chk("R8 disarmed no req", irq_req, 0);
        chk("R8 disarmed ien", ien_o, 0);
        drain("R8 after rearm", 8'h01, 8'hFF);

        // R3 held tick level sets once
        src_req = 8'h02;
        repeat (5) step();
        arm_wait();
        chk("R3 tick vec", irq_vec, 4);
        ack();
        arm_wait();
        chk("R3 held level no repeat", irq_req, 0);
        disarm();
        src_req = '0; step();

        // R10 same-cycle request and acknowledge
        inject(8'h08);
        arm_wait();
        chk("R10 ep0 vec", irq_vec, 8);
        irq_ack = 1'b1; src_req = 8'h08; step();
        irq_ack = 1'b0; src_req = '0;
        arm_wait();
        chk("R10 still pending", irq_req, 1);
        chk("R10 vec", irq_vec, 8);
        ack();

        // R11 frozen against higher priority
        inject(8'h20);
        arm_wait();
        chk("R11 ep2 vec", irq_vec, 12);
        inject(8'h01);
        chk("R11 req held", irq_req, 1);
        chk("R11 vec held", irq_vec, 12);
        ack();
        drain("R11 late", 8'h01, 8'hFF);

        // R6 R7 R9 sweep over every pending pattern
        for (int p = 1; p < 256; p++) begin
            inject(8'(p));
            drain("R9 pattern", 8'(p), 8'hFF);
        end

        // R5 R2 sweep over every enable mask
        for (int m = 0; m < 256; m++) begin
            set_mask(8'(m));
            inject(8'hFF);
            drain("R5 masked", 8'hFF, 8'(m));
            set_mask(8'hFF);
            drain("R2 held flags", 8'hFF, ~8'(m));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule